// File: doc/BRIEF.md
# Bit-Serial Distributed-Arithmetic FIR Filter

This block is an eight-tap finite impulse response filter with no multipliers. Each accepted two's-complement sample is pushed into a tap delay line. A copy of every held sample is then shifted out one bit per clock, least significant bit first. In each cycle the bits of equal weight from all taps form table addresses. The taps are split into two groups of four. Each group reads a 16-entry table that holds every possible sum of its coefficients, and a pre-adder combines the two table outputs.

A scaling accumulator adds each combined partial product at its bit weight. On the final cycle, which handles the sign bit, it subtracts instead of adding. A result takes as many cycles as the sample has bits. The coefficients are fixed by a parameter, and the tables are computed during elaboration. The result width keeps full precision, so no rounding or saturation is applied.

Top module: `da_fir_filter`

## Requirements
- R1: After each accepted sample, out_result equals the sum over k = 0..7 of c_k times x[n-k]. Here x[n] is the newest sample on tap 0, samples and coefficients are two's complement, and c_k is field k (CW bits, tap 0 in the least significant field) of the COEFFS parameter.
- R2: Each accepted sample shifts the tap delay line by exactly one position. Reset clears every tap to zero, so taps that have not yet been filled contribute nothing.
- R3: out_done is high for exactly one cycle. It rises on the DW-th rising edge after the edge that accepted the sample, and the engine is idle again in that same cycle.
- R4: in_valid is ignored while a result is being computed. Such a sample neither reaches the delay line nor alters the result in progress.
- R5: out_result keeps its value from one out_done pulse to the next.
- R6: The most negative sample (-2^(DW-1)) and the most negative coefficient give exact results. This works because the partial product of the sign-bit cycle is subtracted.
- R7: While rst_n is low at a rising edge, the block aborts any computation and drives out_done and out_result to 0 after that edge.
- R8: With c_0 = -7 and c_1 = 6, tap 0 holding 7, tap 1 holding 5 and the other taps zero, the result is -19.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Sample strobe; taken only when idle |
| in_sample | input | DW | Two's-complement sample |
| out_done | output | 1 | One-cycle pulse when out_result is new |
| out_result | output | CW+log2(NTAPS)+DW+1 | Full-precision filter output |

## Verification
On every cycle the assertions check four things: the single-cycle width of the done pulse, its fixed distance of DW cycles from the accepting edge, that the engine is idle when it fires, and that out_result holds between pulses. They also check that the newest tap stays put when in_valid arrives during a computation. The arithmetic itself is covered only by the bench's scenarios, which compare each result against a multiply-accumulate model. These scenarios include the documented -19 case, extreme samples on extreme coefficients, samples injected while busy, and a reset in the middle of a computation that must empty the delay line.

// File: rtl/da_fir_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the distributed-arithmetic FIR filter.
// Assumes: nothing; it holds only the sequencing state encoding.
package da_fir_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } da_state_t;
endpackage

// File: rtl/da_fir_tapline.sv
`timescale 1ns/1ps
// Module: tap delay line plus one parallel-to-serial shifter per tap.
// On load the line advances by one sample and every shifter takes a copy
// of its tap's new value. On step each shifter moves right by one bit, so
// bit k of the sample sits on serial_bits[tap] in the k-th step cycle.
// Assumes: load and step are never high together.
module da_fir_tapline #(
    parameter int NTAPS = 8,
    parameter int DW    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic [DW-1:0]    sample_in,
    output logic [NTAPS-1:0] serial_bits,
    output logic [DW-1:0]    newest
);
    logic [DW-1:0] line [NTAPS];
    logic [DW-1:0] ser  [NTAPS];

    for (genvar k = 0; k < NTAPS; k++) begin : g_tap
        logic [DW-1:0] feed;
        if (k == 0) begin : g_head
            assign feed = sample_in;
        end else begin : g_body
            assign feed = line[k-1];
        end

        // Delay-line stage k: advances only when a sample is accepted.
        always_ff @(posedge clk) begin
            if (!rst_n)       line[k] <= '0;
            else if (load)    line[k] <= feed;
        end

        // Serializer k: loads the stage's new value, then shifts LSB first.
        always_ff @(posedge clk) begin
            if (!rst_n)       ser[k] <= '0;
            else if (load)    ser[k] <= feed;
            else if (step)    ser[k] <= {1'b0, ser[k][DW-1:1]};
        end

        assign serial_bits[k] = ser[k][0];
    end

    assign newest = line[0];
endmodule

// File: rtl/da_fir_pptable.sv
`timescale 1ns/1ps
// Module: partial-product table for one group of K taps.
// Entry a holds the sum of the coefficients whose bit in a is set. Entry 0
// is therefore zero. Contents are computed at elaboration from GCOEF.
// Assumes: K is small (2^K entries); coefficient j sits in GCOEF[j*CW +: CW].
module da_fir_pptable #(
    parameter int              K     = 4,
    parameter int              CW    = 8,
    parameter logic [K*CW-1:0] GCOEF = '0,
    localparam int             TW    = CW + $clog2(K),
    localparam int             SIZE  = 2 ** K
) (
    input  logic [K-1:0]          addr,
    output logic signed [TW-1:0]  pp
);
    function automatic logic signed [TW-1:0] entry_sum(input int a);
        logic signed [TW-1:0] s;
        logic signed [CW-1:0] c;
        s = '0;
        for (int j = 0; j < K; j++) begin
            c = GCOEF[j*CW +: CW];
            if (a[j]) s = s + TW'(c);
        end
        return s;
    endfunction

    logic signed [TW-1:0] rom [SIZE];

    for (genvar a = 0; a < SIZE; a++) begin : g_rom
        localparam logic signed [TW-1:0] ENT = entry_sum(a);
        assign rom[a] = ENT;
    end

    // Table read: one entry per cycle, purely combinational.
    always_comb pp = rom[addr];
endmodule

// File: rtl/da_fir_accum.sv
`timescale 1ns/1ps
// Module: shift-and-add scaling accumulator for LSB-first partial products.
// Each step adds the partial product to the high word (or subtracts it on
// the sign cycle) and shifts one bit right into the low word, so no bits
// are lost. total shows the full-precision value this step would produce.
// Assumes: clear precedes the first step of a result; exactly DW steps.
module da_fir_accum #(
    parameter int  DW = 8,
    parameter int  PW = 11,
    localparam int RW = PW + 1 + DW
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear,
    input  logic                 step,
    input  logic                 sign_cyc,
    input  logic signed [PW-1:0] pp,
    output logic [RW-1:0]        total
);
    logic signed [PW:0]   hi;
    logic [DW-1:0]        lo;
    logic signed [PW+1:0] pp_x;
    logic signed [PW+1:0] t;

    // Add or subtract the weighted partial product.
    always_comb begin
        pp_x  = (PW+2)'(pp);
        t     = (PW+2)'(hi) + (sign_cyc ? -pp_x : pp_x);
        total = {t[PW+1:1], t[0], lo[DW-1:1]};
    end

    // Running value: arithmetic right shift of the sum, low bit saved.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            hi <= '0;
            lo <= '0;
        end else if (step) begin
            hi <= t[PW+1:1];
            lo <= {t[0], lo[DW-1:1]};
        end
    end
endmodule

// File: rtl/da_fir_filter.sv
`timescale 1ns/1ps
// Module: top of the bit-serial distributed-arithmetic FIR filter.
// A sample is accepted when idle. Then DW cycles each form one address per
// tap group, sum the group tables in a pre-adder, and accumulate. The last
// cycle subtracts and registers the result with a done pulse.
// Assumes: NTAPS is a multiple of GRP; coefficient k in COEFFS[k*CW +: CW].
module da_fir_filter
    import da_fir_pkg::*;
#(
    parameter int                  NTAPS  = 8,
    parameter int                  GRP    = 4,
    parameter int                  DW     = 8,
    parameter int                  CW     = 8,
    parameter logic [NTAPS*CW-1:0] COEFFS = {8'd90, 8'd1, 8'hDF, 8'd50,
                                             8'd127, 8'h80, 8'd6, 8'hF9},
    localparam int                 NGRP   = NTAPS / GRP,
    localparam int                 GTW    = CW + $clog2(GRP),
    localparam int                 PW     = CW + $clog2(NTAPS),
    localparam int                 RW     = PW + 1 + DW,
    localparam int                 CNTW   = (DW > 2) ? $clog2(DW) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [DW-1:0]        in_sample,
    output logic                 out_done,
    output logic signed [RW-1:0] out_result
);
    da_state_t            state;
    logic [CNTW-1:0]      bit_cnt;
    logic                 busy, accept, last;
    logic [NTAPS-1:0]     serial_bits;
    logic [DW-1:0]        newest;
    logic signed [GTW-1:0] gpp [NGRP];
    logic signed [PW-1:0] pp_sum;
    logic [RW-1:0]        total;

    assign busy   = (state == ST_RUN);
    assign accept = in_valid && !busy;
    assign last   = busy && (bit_cnt == CNTW'(DW - 1));

    // Sequencer: idle until a sample arrives, then DW bit cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            bit_cnt <= '0;
        end else if (accept) begin
            state   <= ST_RUN;
            bit_cnt <= '0;
        end else if (busy) begin
            bit_cnt <= bit_cnt + 1'b1;
            if (last) state <= ST_IDLE;
        end
    end

    da_fir_tapline #(.NTAPS(NTAPS), .DW(DW)) u_line (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (accept),
        .step       (busy),
        .sample_in  (in_sample),
        .serial_bits(serial_bits),
        .newest     (newest)
    );

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        da_fir_pptable #(
            .K    (GRP),
            .CW   (CW),
            .GCOEF(COEFFS[g*GRP*CW +: GRP*CW])
        ) u_tab (
            .addr(serial_bits[g*GRP +: GRP]),
            .pp  (gpp[g])
        );
    end

    // Pre-adder: joins the group table outputs of equal bit weight.
    always_comb begin
        pp_sum = '0;
        for (int g = 0; g < NGRP; g++) pp_sum = pp_sum + PW'(gpp[g]);
    end

    da_fir_accum #(.DW(DW), .PW(PW)) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (accept),
        .step    (busy),
        .sign_cyc(last),
        .pp      (pp_sum),
        .total   (total)
    );

    // Output register: captures the final sum and pulses done once.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_done   <= 1'b0;
            out_result <= '0;
        end else begin
            out_done <= last;
            if (last) out_result <= $signed(total);
        end
    end
endmodule

// File: rtl/da_fir_checker.sv
`timescale 1ns/1ps
// Module: protocol checker for da_fir_filter, bound into every instance.
// Tracks cycles since acceptance with its own counter.
// Assumes: busy is the top's run flag and newest its tap-0 register.
module da_fir_checker #(
    parameter int DW = 8,
    parameter int RW = 20
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          busy,
    input logic [DW-1:0] newest,
    input logic          out_done,
    input logic [RW-1:0] out_result
);
    localparam int CNW = $clog2(DW + 2) + 1;
    logic [CNW-1:0] since;

    // Cycle counter from the accepting edge, saturating at all ones.
    always_ff @(posedge clk) begin
        if (!rst_n)                   since <= '1;
        else if (in_valid && !busy)   since <= '0;
        else if (since != '1)         since <= since + 1'b1;
    end

    p_done_one_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_done |=> !out_done);
    p_done_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_done |-> (since == CNW'(DW)));
    p_done_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_done |-> !busy);
    p_busy_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && in_valid) |=> $stable(newest));
    p_result_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !out_done |-> $stable(out_result));
endmodule

bind da_fir_filter da_fir_checker #(.DW(DW), .RW(RW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .busy      (busy),
    .newest    (newest),
    .out_done  (out_done),
    .out_result(out_result)
);

// File: tb/da_fir_filter_test.sv
`timescale 1ns/1ps
module da_fir_filter_test;
    localparam int NTAPS = 8;
    localparam int DW    = 8;
    localparam int CW    = 8;
    localparam int RW    = CW + 3 + 1 + DW;
    localparam int COEF [NTAPS] = '{-7, 6, -128, 127, 50, -33, 1, 90};
    localparam logic [NTAPS*CW-1:0] CPACK = {8'd90, 8'd1, 8'hDF, 8'd50,
                                             8'd127, 8'h80, 8'd6, 8'hF9};
    localparam int NVEC = 16;
    localparam int STIM [NVEC] = '{-128, 127, -1, 0, 1, -128, -128, 64,
                                   -77, 99, -128, -128, -128, -128, 127, 3};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [DW-1:0] in_sample = '0;
    logic out_done;
    logic signed [RW-1:0] out_result;

    int hist [NTAPS];
    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    da_fir_filter #(.NTAPS(NTAPS), .GRP(4), .DW(DW), .CW(CW), .COEFFS(CPACK)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
        .out_done(out_done), .out_result(out_result)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int ref_out();
        int s = 0;
        for (int k = 0; k < NTAPS; k++) s += COEF[k] * hist[k];
        return s;
    endfunction

    // Push one sample at a negedge, optionally inject junk while busy,
    // check done timing and the value on the DW-th edge after acceptance.
    task automatic run_sample(input int x, input bit inject, input string req);
        in_valid  = 1'b1;
        in_sample = x[DW-1:0];
        for (int k = NTAPS-1; k > 0; k--) hist[k] = hist[k-1];
        hist[0] = x;
        @(negedge clk);
        for (int k = 1; k < DW; k++) begin
            in_valid  = inject && (k <= 3);
            in_sample = 8'd99;
            @(negedge clk);
            chk({req, "/R3 done early"}, int'(out_done), 0);
        end
        in_valid = 1'b0;
        @(negedge clk);
        chk({req, "/R3 done"}, int'(out_done), 1);
        chk(req, int'(out_result), ref_out());
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        int held;
        for (int k = 0; k < NTAPS; k++) hist[k] = 0;
        repeat (4) @(negedge clk);
        chk("R7 reset done", int'(out_done), 0);
        chk("R7 reset result", int'(out_result), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1/R2: first sample on an empty line, then the documented case.
        run_sample(5, 1'b0, "R1 single");
        chk("R2 empty taps", int'(out_result), -35);
        run_sample(7, 1'b0, "R8 two-tap");
        chk("R8 value", int'(out_result), -19);

        // Vector table: extremes drive R6, the rest R1; R5 hold after done.
        for (int i = 0; i < NVEC; i++) begin
            run_sample(STIM[i], 1'b0, (STIM[i] == -128) ? "R6 extreme" : "R1 table");
            held = int'(out_result);
            @(negedge clk);
            chk("R3 pulse width", int'(out_done), 0);
            chk("R5 hold", int'(out_result), held);
        end

        // R4: junk offered while busy must not reach the line.
        run_sample(33, 1'b1, "R4 busy inject");
        run_sample(10, 1'b0, "R4 line untouched");

        // R7/R2: reset in mid-computation clears outputs and the line.
        in_valid  = 1'b1;
        in_sample = 8'd50;
        @(negedge clk);
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R7 abort done", int'(out_done), 0);
        chk("R7 abort result", int'(out_result), 0);
        rst_n = 1'b1;
        for (int k = 0; k < NTAPS; k++) hist[k] = 0;
        @(negedge clk);
        run_sample(3, 1'b0, "R2 cleared line");
        chk("R2 cleared value", int'(out_result), -21);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule